// File: doc/BRIEF.md
# Programmable-Duty Clock Doubler

The block turns a slow reference clock into a clock of twice its frequency, and the high time of each of the two output cycles is set separately. All of its timing comes from a sample clock that runs at exactly 32 times the reference frequency. A 5-bit slot counter restarts on every sampled rising edge of the reference, so each reference period splits into 32 slots. Slots 0 to 15 form the first doubled cycle, which lies in the reference high phase. Slots 16 to 31 form the second doubled cycle, which lies in the low phase.

Three byte-wide registers are written through a simple write port. The duty register holds two 4-bit high-time codes. The mode register holds the doubler enable. The route register holds a 2-bit select for each output: one output feeds a dedicated fast clock path and the other feeds the system clock path. Register writes go to a staging copy. The staging copy moves into the active copy only on a reference rising edge, so a period that has already started always finishes with the settings it began with.

Top module: `duty_doubler`

## Requirements
- R1: While the active mode bit (bit 4 of the register at address 5) is 0, each output equals the reference input sampled one sample-clock edge earlier, whatever the route selects are.
- R2: With the doubler active, each reference period produces two output cycles. The first covers slots 0 to 15, counted from the sampled reference rising edge. The second covers slots 16 to 31. Each cycle starts high in its first slot and ends low in its last slot.
- R3: The first cycle is high for n+1 slots and low for the rest of its 16 slots. Here n is the code {duty[7], duty[5:3]} from the register at address 3.
- R4: The second cycle is high for m+1 slots and low for the rest of its 16 slots. Here m is the code {duty[6], duty[2:0]}.
- R5: A code of 15 acts as 14, so it gives 15 high slots and 1 low slot.
- R6: The fast output carries the doubled clock only when bits [5:3]... specifically bits [5:4] of the register at address 6 equal 01. Any other value drives it low while the doubler is active.
- R7: The system output carries the doubled clock only when bits [7:6] of the register at address 6 equal 01. Any other value drives it low while the doubler is active.
- R8: A register write does not change the current reference period. It takes effect from the next sampled reference rising edge.
- R9: While reset is asserted, and after reset until the reference first goes high, both outputs are low.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, 32 times the reference frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address (3 duty, 5 mode, 6 route) |
| wr_data_i | input | 8 | Register write data |
| fast_clk_o | output | 1 | Doubled clock for the dedicated fast path |
| sys_clk_o | output | 1 | Doubled clock for the system path |

## Verification
The reference rise is seen at a sample edge. The next edge outputs slot 0, so when the reference goes high at the bench's sampling point, the output level for slot j appears two samples later. The bench therefore maps sample m of a period to slot (m+30) mod 32. Pass-through output lags the reference by one sample edge, so sample m is compared with reference phase m-1. A new setting becomes active at the next reference rise. For that reason the sweep checks only the third period after each write, and the write-timing check expects the first two samples of the following period to still show the old setting.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int SLOT_W = 5;
  localparam int HALF_W = SLOT_W - 1;
  localparam int MODE_BIT = 4;
  localparam logic [1:0] ROUTE_ON = 2'b01;
  localparam logic [HALF_W-1:0] CODE_MAX = HALF_W'(14);

  typedef logic [HALF_W-1:0] code_t;

  typedef struct packed {
    logic       mode;
    logic [1:0] fast_sel;
    logic [1:0] sys_sel;
    logic [7:0] duty;
  } cfg_t;

  function automatic code_t clamp_code(code_t c);
    return (c > CODE_MAX) ? CODE_MAX : c;
  endfunction
endpackage

// File: rtl/dbl_phase.sv
module dbl_phase #(
  parameter int SLOT_W = dbl_pkg::SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  output logic              rise_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic ref_q;

  assign rise_o = ref_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= 1'b0;
      slot_o <= '0;
    end else begin
      ref_q  <= ref_i;
      slot_o <= rise_o ? '0 : slot_o + 1'b1;
    end
  end
endmodule

// File: rtl/dbl_regs.sv
module dbl_regs #(
  parameter int ADDR_W     = 3,
  parameter int ADDR_DUTY  = 3,
  parameter int ADDR_MODE  = 5,
  parameter int ADDR_ROUTE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              load_i,
  output dbl_pkg::cfg_t     act_o
);
  import dbl_pkg::*;

  cfg_t stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_W'(ADDR_DUTY))  stage_q.duty <= wr_data_i;
      if (wr_addr_i == ADDR_W'(ADDR_MODE))  stage_q.mode <= wr_data_i[MODE_BIT];
      if (wr_addr_i == ADDR_W'(ADDR_ROUTE)) begin
        stage_q.fast_sel <= wr_data_i[5:4];
        stage_q.sys_sel  <= wr_data_i[7:6];
      end
    end
  end

  // active copy only moves at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_o <= '0;
    else if (load_i) act_o <= stage_q;
  end
endmodule

// File: rtl/dbl_wave.sv
module dbl_wave #(
  parameter int SLOT_W = dbl_pkg::SLOT_W
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [7:0]        duty_i,
  output logic              hi_o
);
  import dbl_pkg::*;

  code_t code_a, code_b, code_sel;

  assign code_a   = {duty_i[7], duty_i[5:3]};
  assign code_b   = {duty_i[6], duty_i[2:0]};
  assign code_sel = clamp_code(slot_i[SLOT_W-1] ? code_b : code_a);
  assign hi_o     = slot_i[SLOT_W-2:0] <= code_sel;
endmodule

// File: rtl/duty_doubler.sv
module duty_doubler #(
  parameter int ADDR_W     = 3,
  parameter int ADDR_DUTY  = 3,
  parameter int ADDR_MODE  = 5,
  parameter int ADDR_ROUTE = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              fast_clk_o,
  output logic              sys_clk_o
);
  import dbl_pkg::*;

  localparam int N_OUT = 2;

  logic              rise;
  logic [SLOT_W-1:0] slot;
  cfg_t              act;
  logic              act_mode;
  logic [1:0]        act_fast_sel, act_sys_sel;
  logic [7:0]        act_duty;
  logic              wave_hi;
  logic [1:0]        sel   [N_OUT];
  logic [N_OUT-1:0]  out_q;

  dbl_phase #(.SLOT_W(SLOT_W)) i_phase (
    .clk_i, .rst_ni, .ref_i, .rise_o(rise), .slot_o(slot)
  );

  dbl_regs #(
    .ADDR_W(ADDR_W), .ADDR_DUTY(ADDR_DUTY),
    .ADDR_MODE(ADDR_MODE), .ADDR_ROUTE(ADDR_ROUTE)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(rise), .act_o(act)
  );

  dbl_wave #(.SLOT_W(SLOT_W)) i_wave (
    .slot_i(slot), .duty_i(act_duty), .hi_o(wave_hi)
  );

  assign act_mode     = act.mode;
  assign act_fast_sel = act.fast_sel;
  assign act_sys_sel  = act.sys_sel;
  assign act_duty     = act.duty;
  assign sel[0]       = act_fast_sel;
  assign sel[1]       = act_sys_sel;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       out_q[g] <= 1'b0;
      else if (act_mode) out_q[g] <= (sel[g] == ROUTE_ON) & wave_hi;
      else               out_q[g] <= ref_i;
    end
  end

  assign fast_clk_o = out_q[0];
  assign sys_clk_o  = out_q[1];
endmodule

// File: rtl/duty_doubler_chk.sv
module duty_doubler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ref_i,
  input logic       rise,
  input logic [4:0] slot,
  input logic       act_mode,
  input logic [1:0] act_fast_sel,
  input logic [1:0] act_sys_sel,
  input logic [7:0] act_duty,
  input logic       fast_clk_o,
  input logic       sys_clk_o
);
  a_r1_fast_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_mode |=> fast_clk_o == $past(ref_i));
  a_r1_sys_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_mode |=> sys_clk_o == $past(ref_i));
  a_r2_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> slot == $past(slot) + 5'd1);
  a_r2_half_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode && act_fast_sel == 2'b01 && slot[3:0] == 4'h0 |=> fast_clk_o);
  a_r5_half_end_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode && act_fast_sel == 2'b01 && slot[3:0] == 4'hf |=> !fast_clk_o);
  a_r6_fast_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode && act_fast_sel != 2'b01 |=> !fast_clk_o);
  a_r7_sys_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_mode && act_sys_sel != 2'b01 |=> !sys_clk_o);
  a_r8_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(act_duty) && $stable(act_mode));
  always_comb begin
    if (!rst_ni) a_r9_reset_low: assert (!fast_clk_o && !sys_clk_o);
  end
endmodule

bind duty_doubler duty_doubler_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .rise(rise), .slot(slot),
  .act_mode(act_mode), .act_fast_sel(act_fast_sel), .act_sys_sel(act_sys_sel),
  .act_duty(act_duty), .fast_clk_o(fast_clk_o), .sys_clk_o(sys_clk_o)
);

// File: tb/test_duty_doubler.sv
`timescale 1ns/1ps
module test_duty_doubler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       fast_clk_o, sys_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  duty_doubler i_duty_doubler (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 200000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual %0d cycles, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // sample m of a period shows slot (m+30)%32
  function automatic logic [31:0] exp_wave(input int c1, input int c2);
    logic [31:0] v;
    for (int m = 0; m < 32; m++) begin
      int j = (m + 30) % 32;
      int c = (j < 16) ? c1 : c2;
      if (c > 14) c = 14;
      v[m] = (j % 16) <= c;
    end
    return v;
  endfunction

  function automatic logic [31:0] exp_pass();
    logic [31:0] v;
    for (int m = 0; m < 32; m++) v[m] = ((m + 31) % 32) < 16;
    return v;
  endfunction

  function automatic logic [7:0] pack_duty(input int c1, input int c2);
    logic [3:0] a = 4'(c1), b = 4'(c2);
    return {a[3], b[3], a[2:0], b[2:0]};
  endfunction

  // one 32-slot reference period, optional write at sample 20
  task automatic run_period(input bit do_wr, input logic [2:0] addr, input logic [7:0] data,
                            output logic [31:0] fv, output logic [31:0] sv);
    for (int m = 0; m < 32; m++) begin
      @(negedge clk_i);
      fv[m] = fast_clk_o;
      sv[m] = sys_clk_o;
      ref_i = (m < 16);
      wr_en_i = do_wr && (m == 20);
      wr_addr_i = addr;
      wr_data_i = data;
    end
  endtask

  initial begin
    logic [31:0] fv, sv, ea, eb;
    repeat (3) @(negedge clk_i);
    check("R9 reset", {62'd0, fast_clk_o, sys_clk_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 idle after reset", {62'd0, fast_clk_o, sys_clk_o}, 64'd0);

    // R1 pass-through, route bits set but mode off
    run_period(1, 3'd6, 8'b0101_0000, fv, sv);
    run_period(1, 3'd3, pack_duty(3, 9), fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R1 pass-through", {sv, fv}, {exp_pass(), exp_pass()});
    run_period(1, 3'd1, 8'hff, fv, sv);   // unused address, ignored
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R1 unused address", {sv, fv}, {exp_pass(), exp_pass()});

    // enable doubler
    run_period(1, 3'd5, 8'h10, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R2 R3 R4 enable", {sv, fv}, {exp_wave(3, 9), exp_wave(3, 9)});

    // R3 R4 exhaustive sweep of legal codes
    for (int c1 = 0; c1 < 15; c1++)
      for (int c2 = 0; c2 < 15; c2++) begin
        run_period(1, 3'd3, pack_duty(c1, c2), fv, sv);
        run_period(0, 3'd0, 8'd0, fv, sv);
        run_period(0, 3'd0, 8'd0, fv, sv);
        check($sformatf("R3 R4 codes %0d/%0d", c1, c2), {sv, fv},
              {exp_wave(c1, c2), exp_wave(c1, c2)});
      end

    // R5 clamp
    begin
      int cl [3][2] = '{'{15, 15}, '{15, 4}, '{0, 15}};
      for (int k = 0; k < 3; k++) begin
        run_period(1, 3'd3, pack_duty(cl[k][0], cl[k][1]), fv, sv);
        run_period(0, 3'd0, 8'd0, fv, sv);
        run_period(0, 3'd0, 8'd0, fv, sv);
        check("R5 clamp", {sv, fv}, {exp_wave(cl[k][0], cl[k][1]), exp_wave(cl[k][0], cl[k][1])});
      end
    end

    // R8 write mid-period leaves current period intact
    run_period(1, 3'd3, pack_duty(2, 12), fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    ea = exp_wave(2, 12);
    eb = exp_wave(11, 5);
    run_period(1, 3'd3, pack_duty(11, 5), fv, sv);
    check("R8 same period", {32'd0, fv}, {32'd0, ea});
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R8 next period", {32'd0, fv}, {32'd0, (eb & ~32'h3) | (ea & 32'h3)});

    // R6 R7 routing
    run_period(1, 3'd6, 8'b1001_0000, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R7 sys off", {sv, fv}, {32'd0, eb});
    run_period(1, 3'd6, 8'b0110_0000, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R6 fast off", {sv, fv}, {eb, 32'd0});
    run_period(1, 3'd6, 8'b0000_0000, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R6 R7 both off", {sv, fv}, 64'd0);

    // R1 back to pass-through with routes off
    run_period(1, 3'd5, 8'hef, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    run_period(0, 3'd0, 8'd0, fv, sv);
    check("R1 mode off", {sv, fv}, {exp_pass(), exp_pass()});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule